// File: doc/BRIEF.md
# Multi-Lane Link Scrambler

This block sits on the transmit path of a multi-lane serial link, between framing and line encoding. Every symbol time it takes one byte per lane, with a flag that marks control (K) symbols and flags that mark bytes from an ordered set or a compliance pattern. Each qualifying data byte is XORed with a key byte taken from a 16-bit linear feedback shift register. One register serves all lanes, so every lane sees the same key in the same symbol time and the lanes never drift apart. The K flag travels with its byte, and the result is registered.

Only packet data and logical idle bytes are changed. Control symbols, ordered-set data and compliance data pass through as they came. A COM control symbol loads the register with all ones, so both ends of the link restart the sequence together. A SKP control symbol freezes it, so inserted or deleted skips do not upset the receiver. A test input switches the XOR off while the register keeps its normal sequence. The XOR is its own inverse and the rules depend only on the flags, so the same block works as the receive-side descrambler.

Top module: `lane_scrambler`

## Requirements
- R1: Synchronous reset (rst high) clears out_valid, out_sym and out_k to zero and loads the register with 16'hFFFF, so the first data symbol after reset is XORed with 8'hFF.
- R2: A data byte (in_k, in_os and in_cp all low for its lane) in a valid symbol time with scr_off low appears on out_sym, one cycle later, XORed with the key byte. The key byte is the low 8 bits of the register value held before that symbol time.
- R3: The register is a left-shifting Galois LFSR for X^16+X^5+X^4+X^3+1 (feedback mask 16'h0039). It advances 8 shifts per valid symbol time unless R7 or R8 applies, and all lanes use the same key byte in the same symbol time. Starting from 16'hFFFF, the keys are 8'hFF, 8'h17, 8'h28.
- R4: A lane with in_k high is passed unchanged, and its out_k is high one cycle later.
- R5: A lane with in_os high (ordered-set data) is passed unchanged.
- R6: A lane with in_cp high (compliance pattern data) is passed unchanged.
- R7: A valid symbol time with lane 0 holding COM (in_k high, code 8'hBC) reloads the register with 16'hFFFF for the next symbol time.
- R8: A valid symbol time with lane 0 holding SKP (in_k high, code 8'h1C) leaves the register unchanged.
- R9: With scr_off high, every lane passes unchanged, and the register still advances as in R3.
- R10: A cycle with in_valid low leaves the register unchanged.
- R11: Feeding the block's output stream back through it, after a reset and with the same flags, returns the original bytes.
- R12: out_valid equals in_valid delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A symbol time is present on all lanes |
| scr_off | input | 1 | Test bypass: no XOR is applied while high |
| in_sym | input | LANES*8 | Input bytes, lane 0 in bits 7:0 |
| in_k | input | LANES | Per-lane control-symbol flag |
| in_os | input | LANES | Per-lane ordered-set data flag |
| in_cp | input | LANES | Per-lane compliance pattern flag |
| out_valid | output | 1 | Registered valid |
| out_sym | output | LANES*8 | Scrambled or passed bytes, lane 0 in bits 7:0 |
| out_k | output | LANES | Registered control-symbol flags |

## Verification
The checker takes it for granted that ordered sets arrive on all lanes in the same symbol time. COM and SKP are therefore decoded from lane 0 alone, and the register-control properties are written against lane 0. The vector table and the directed tests put COM and SKP on every lane at once. The round-trip stream may carry other K codes on single lanes, and both of its passes handle them the same way. The checker also assumes that the flags are only examined in cycles with in_valid high, and the stimulus drives them only in those cycles.

// File: rtl/lane_scr_pkg.sv
package lane_scr_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] K_COM = 8'hBC;
  localparam logic [CODE_W-1:0] K_SKP = 8'h1C;

  typedef struct packed {
    logic k;
    logic os;
    logic cp;
  } lane_tag_t;
endpackage

// File: rtl/lane_scr_lfsr.sv
module lane_scr_lfsr #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] POLY = 16'h0039,
  parameter logic [W-1:0] SEED = 16'hFFFF,
  parameter int unsigned STEPS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         reseed,
  output logic [W-1:0] state_q
);
  logic [W-1:0] state_nxt;

  function automatic logic [W-1:0] walk(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = s;
    for (int n = 0; n < STEPS; n++) begin
      t = {t[W-2:0], 1'b0} ^ (t[W-1] ? POLY : '0);
    end
    return t;
  endfunction

  always_comb state_nxt = walk(state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (reseed) begin
      state_q <= SEED;
    end else if (adv) begin
      state_q <= state_nxt;
    end
  end
endmodule

// File: rtl/lane_scr_ctl.sv
module lane_scr_ctl
  import lane_scr_pkg::*;
#(
  parameter int unsigned SYM_W = 8
) (
  input  logic             in_valid,
  input  logic [SYM_W-1:0] sym0,
  input  logic             k0,
  output logic             reseed,
  output logic             adv
);
  logic is_com, is_skp;

  always_comb begin
    is_com = k0 && (sym0 == SYM_W'(K_COM));
    is_skp = k0 && (sym0 == SYM_W'(K_SKP));
    reseed = in_valid && is_com;
    adv    = in_valid && !is_skp;
  end
endmodule

// File: rtl/lane_scr_lane.sv
module lane_scr_lane
  import lane_scr_pkg::*;
#(
  parameter int unsigned SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             bypass,
  input  logic [SYM_W-1:0] key,
  input  logic [SYM_W-1:0] sym,
  input  lane_tag_t        tag,
  output logic [SYM_W-1:0] sym_q,
  output logic             k_q
);
  logic             mix;
  logic [SYM_W-1:0] sym_nxt;

  always_comb begin
    mix     = !bypass && !tag.k && !tag.os && !tag.cp;
    sym_nxt = mix ? (sym ^ key) : sym;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q <= '0;
      k_q   <= 1'b0;
    end else if (ld) begin
      sym_q <= sym_nxt;
      k_q   <= tag.k;
    end
  end
endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler
  import lane_scr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned SYM_W  = 8,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] POLY = 16'h0039,
  parameter logic [LFSR_W-1:0] SEED = 16'hFFFF,
  parameter int unsigned STEPS  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   scr_off,
  input  logic [LANES*SYM_W-1:0] in_sym,
  input  logic [LANES-1:0]       in_k,
  input  logic [LANES-1:0]       in_os,
  input  logic [LANES-1:0]       in_cp,
  output logic                   out_valid,
  output logic [LANES*SYM_W-1:0] out_sym,
  output logic [LANES-1:0]       out_k
);
  localparam int unsigned BUS_W = LANES * SYM_W;

  logic [LFSR_W-1:0] lfsr_q;
  logic [SYM_W-1:0]  key;
  logic              reseed, adv;

  lane_scr_ctl #(.SYM_W(SYM_W)) u_ctl (
    .in_valid (in_valid),
    .sym0     (in_sym[SYM_W-1:0]),
    .k0       (in_k[0]),
    .reseed   (reseed),
    .adv      (adv)
  );

  lane_scr_lfsr #(.W(LFSR_W), .POLY(POLY), .SEED(SEED), .STEPS(STEPS)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .reseed  (reseed),
    .state_q (lfsr_q)
  );

  assign key = lfsr_q[SYM_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_tag_t tag;
    assign tag = '{k: in_k[g], os: in_os[g], cp: in_cp[g]};

    lane_scr_lane #(.SYM_W(SYM_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .ld     (in_valid),
      .bypass (scr_off),
      .key    (key),
      .sym    (in_sym[g*SYM_W +: SYM_W]),
      .tag    (tag),
      .sym_q  (out_sym[g*SYM_W +: SYM_W]),
      .k_q    (out_k[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  if (BUS_W < SYM_W) begin : g_bad_cfg
    initial $fatal(1, "lane_scrambler: bus narrower than one symbol");
  end
endmodule

// File: rtl/lane_scrambler_chk.sv
module lane_scrambler_chk
  import lane_scr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned SYM_W  = 8,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hFFFF
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   scr_off,
  input logic [LANES*SYM_W-1:0] in_sym,
  input logic [LANES-1:0]       in_k,
  input logic [LANES-1:0]       in_os,
  input logic [LANES-1:0]       in_cp,
  input logic                   out_valid,
  input logic [LANES*SYM_W-1:0] out_sym,
  input logic [LANES-1:0]       out_k,
  input logic [LFSR_W-1:0]      lfsr_q
);
  logic com0, skp0;
  assign com0 = in_k[0] && (in_sym[SYM_W-1:0] == SYM_W'(K_COM));
  assign skp0 = in_k[0] && (in_sym[SYM_W-1:0] == SYM_W'(K_SKP));

  a_r12_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r12_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r7_com_reseed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && com0) |=> (lfsr_q == SEED));
  a_r8_skp_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && skp0) |=> $stable(lfsr_q));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(lfsr_q));
  a_r3_moves: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_k[0]) |=> (lfsr_q != $past(lfsr_q)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r4_k_pass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_k[g]) |=>
        (out_k[g] && out_sym[g*SYM_W +: SYM_W] == $past(in_sym[g*SYM_W +: SYM_W])));
    a_r5_os_pass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_os[g]) |=>
        (out_sym[g*SYM_W +: SYM_W] == $past(in_sym[g*SYM_W +: SYM_W])));
    a_r6_cp_pass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_cp[g]) |=>
        (out_sym[g*SYM_W +: SYM_W] == $past(in_sym[g*SYM_W +: SYM_W])));
    a_r9_off_pass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && scr_off) |=>
        (out_sym[g*SYM_W +: SYM_W] == $past(in_sym[g*SYM_W +: SYM_W])));
  end
endmodule

bind lane_scrambler lane_scrambler_chk #(
  .LANES(LANES), .SYM_W(SYM_W), .LFSR_W(LFSR_W), .SEED(SEED)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .scr_off(scr_off),
  .in_sym(in_sym), .in_k(in_k), .in_os(in_os), .in_cp(in_cp),
  .out_valid(out_valid), .out_sym(out_sym), .out_k(out_k), .lfsr_q(lfsr_q)
);

// File: tb/lane_scrambler_tb.sv
`timescale 1ns/1ps
module lane_scrambler_tb;
  localparam int LANES = 4;
  localparam int NRT   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, scr_off = 1'b0;
  logic [31:0] in_sym = '0;
  logic [3:0]  in_k = '0, in_os = '0, in_cp = '0;
  logic        out_valid;
  logic [31:0] out_sym;
  logic [3:0]  out_k;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lane_scrambler u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .scr_off(scr_off),
    .in_sym(in_sym), .in_k(in_k), .in_os(in_os), .in_cp(in_cp),
    .out_valid(out_valid), .out_sym(out_sym), .out_k(out_k)
  );

  typedef struct packed {
    logic        vld;
    logic        off;
    logic [31:0] sym;
    logic [3:0]  k;
    logic [3:0]  os;
    logic [3:0]  cp;
    logic        exp_vld;
    logic [31:0] exp_sym;
    logic [3:0]  exp_k;
    logic [7:0]  req;
  } vec_t;

  // Keys from a fresh 16'hFFFF seed: FF, 17, 28 (R3).
  localparam vec_t TBL [0:8] = '{
    '{1'b1, 1'b0, 32'h44332211, 4'h0, 4'h0, 4'h0, 1'b1, 32'hBBCCDDEE, 4'h0, 8'd2},  // R2 key FF
    '{1'b1, 1'b0, 32'h1C1C1C1C, 4'hF, 4'h0, 4'h0, 1'b1, 32'h1C1C1C1C, 4'hF, 8'd8},  // R8 SKP
    '{1'b1, 1'b0, 32'h00000000, 4'h0, 4'h0, 4'h0, 1'b1, 32'h17171717, 4'h0, 8'd3},  // R3 idle, key 17
    '{1'b1, 1'b0, 32'h4A4A4A4A, 4'h0, 4'hF, 4'h0, 1'b1, 32'h4A4A4A4A, 4'h0, 8'd5},  // R5 os data
    '{1'b1, 1'b0, 32'hBCBCBCBC, 4'hF, 4'h0, 4'h0, 1'b1, 32'hBCBCBCBC, 4'hF, 8'd7},  // R7 COM
    '{1'b1, 1'b0, 32'h5AC5FB00, 4'h2, 4'h0, 4'h4, 1'b1, 32'hA5C5FBFF, 4'h2, 8'd6},  // R4 R6 mixed
    '{1'b1, 1'b1, 32'h12345678, 4'h0, 4'h0, 4'h0, 1'b1, 32'h12345678, 4'h0, 8'd9},  // R9 off
    '{1'b0, 1'b0, 32'h00000000, 4'h0, 4'h0, 4'h0, 1'b0, 32'h00000000, 4'h0, 8'd12}, // R12 R10 bubble
    '{1'b1, 1'b0, 32'hFFFFFFFF, 4'h0, 4'h0, 4'h0, 1'b1, 32'hD7D7D7D7, 4'h0, 8'd10}  // R10 key 28
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic off, input logic [31:0] s,
                       input logic [3:0] k, input logic [3:0] os, input logic [3:0] cp);
    @(negedge clk);
    in_valid = v; scr_off = off; in_sym = s; in_k = k; in_os = os; in_cp = cp;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk(out_valid == 1'b0, 1, "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk(out_sym == 32'd0, 1, "reset out_sym", out_sym, 32'd0);
    chk(out_k == 4'd0, 1, "reset out_k", {28'd0, out_k}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [31:0] rt_sym [NRT];
  logic [31:0] rt_out [NRT];
  logic [3:0]  rt_k   [NRT];
  logic [3:0]  rt_os  [NRT];
  logic [3:0]  rt_cp  [NRT];
  logic        rt_off [NRT];

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();  // R1

    // Vector table walk.
    for (int i = 0; i < 9; i++) begin
      drive(TBL[i].vld, TBL[i].off, TBL[i].sym, TBL[i].k, TBL[i].os, TBL[i].cp);
      chk(out_valid == TBL[i].exp_vld, int'(TBL[i].req), $sformatf("row %0d valid", i),
          {31'd0, out_valid}, {31'd0, TBL[i].exp_vld});
      if (TBL[i].exp_vld) begin
        chk(out_sym == TBL[i].exp_sym, int'(TBL[i].req), $sformatf("row %0d sym", i),
            out_sym, TBL[i].exp_sym);
        chk(out_k == TBL[i].exp_k, int'(TBL[i].req), $sformatf("row %0d k", i),
            {28'd0, out_k}, {28'd0, TBL[i].exp_k});
      end
    end
    drive(1'b0, 1'b0, '0, '0, '0, '0);

    // R1: reset mid-stream restores the all-ones seed.
    do_reset();
    drive(1'b1, 1'b0, 32'h00000000, '0, '0, '0);
    chk(out_sym == 32'hFFFFFFFF, 1, "seed after reset", out_sym, 32'hFFFFFFFF);
    // R7: COM on all lanes twice in a row, then data still uses key FF.
    drive(1'b1, 1'b0, 32'hBCBCBCBC, 4'hF, '0, '0);
    drive(1'b1, 1'b0, 32'hBCBCBCBC, 4'hF, '0, '0);
    drive(1'b1, 1'b0, 32'h0F0F0F0F, '0, '0, '0);
    chk(out_sym == 32'hF0F0F0F0, 7, "key after COM", out_sym, 32'hF0F0F0F0);
    // R8: consecutive SKPs hold the register; next key is 17.
    drive(1'b1, 1'b0, 32'h1C1C1C1C, 4'hF, '0, '0);
    drive(1'b1, 1'b0, 32'h1C1C1C1C, 4'hF, '0, '0);
    drive(1'b1, 1'b0, 32'h17171717, '0, '0, '0);
    chk(out_sym == 32'h00000000, 8, "key after SKPs", out_sym, 32'h00000000);
    drive(1'b0, 1'b0, '0, '0, '0, '0);

    // R11: round trip through the block.
    for (int i = 0; i < NRT; i++) begin
      rt_sym[i] = {8'(i * 29 + 3), 8'(i * 53 + 7), 8'(i * 17 + 11), 8'(i * 91 + 5)};
      rt_k[i]   = (i % 7 == 3) ? 4'b0010 : 4'b0000;
      if (i % 9 == 0) begin rt_sym[i] = 32'hBCBCBCBC; rt_k[i] = 4'hF; end
      if (i % 9 == 5) begin rt_sym[i] = 32'h1C1C1C1C; rt_k[i] = 4'hF; end
      rt_os[i]  = (i % 11 == 4) ? 4'hF : 4'h0;
      rt_cp[i]  = (i % 13 == 6) ? 4'b1000 : 4'b0000;
      rt_off[i] = (i == 20);
    end
    do_reset();
    for (int i = 0; i < NRT; i++) begin
      drive(1'b1, rt_off[i], rt_sym[i], rt_k[i], rt_os[i], rt_cp[i]);
      rt_out[i] = out_sym;
    end
    drive(1'b0, 1'b0, '0, '0, '0, '0);
    do_reset();
    for (int i = 0; i < NRT; i++) begin
      drive(1'b1, rt_off[i], rt_out[i], rt_k[i], rt_os[i], rt_cp[i]);
      chk(out_sym == rt_sym[i], 11, $sformatf("round trip %0d", i), out_sym, rt_sym[i]);
    end
    drive(1'b0, 1'b0, '0, '0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule